// File: doc/BRIEF.md
# Dual-Port Line Memory with Serial Row Streaming

This block is a small video-style memory with two ports. The random port reads and writes single words by row and column address. The serial port is read-only. It never addresses the array itself; it emits words from an internal shift register.

A transfer request on the random port copies one whole row into the shift register in one clock. After that, each single-cycle shift enable presents the next word in ascending column order. One row is sized to hold one display line. While a line streams, the random port keeps reading and writing the array, and those accesses do not disturb the words already loaded for streaming.

The storage array and the line register are built from flip-flops. The random read port has one cycle of latency, and all outputs come straight from registers.

Top module: `dual_port_line_mem`

## Requirements
- R1: After reset, `ser_eol` is 1, `ser_data` is 0 and `rp_rvalid` is 0.
- R2: A write (`rp_en`=1, `rp_we`=1) stores `rp_wdata` at (`rp_row`, `rp_col`). A read (`rp_en`=1, `rp_we`=0) returns that word on `rp_rdata` with `rp_rvalid`=1 in the following cycle. `rp_rvalid` is 0 after any cycle that holds no read.
- R3: In the cycle after `xfer_req`=1, `ser_data` holds column 0 of row `xfer_row` and `ser_eol` is 0.
- R4: Each `sclk_en` pulse moves `ser_data` to the next higher column of the loaded row. In a cycle without a pulse, `ser_data` holds its value.
- R5: A pulse that arrives while the last column is shown sets `ser_eol` to 1. From then until the next transfer, `ser_data` keeps the last column's word and further pulses have no effect.
- R6: Random-port writes to the row being streamed, made after its transfer, do not change the serial words. Reads of that row on the random port return the new data.
- R7: When a write and a transfer of the same row happen in the same cycle, the write is applied first and the transfer carries the newly written word.
- R8: When `xfer_req` and `sclk_en` are both 1 in one cycle, the transfer wins and streaming restarts at column 0.
- R9: A random-port read and a transfer in the same cycle are both performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rp_en | input | 1 | Random-port access strobe |
| rp_we | input | 1 | 1 = write, 0 = read |
| rp_row | input | RAW | Random-port row address |
| rp_col | input | CAW | Random-port column address |
| rp_wdata | input | DW | Write data |
| rp_rdata | output | DW | Read data, valid one cycle after the read |
| rp_rvalid | output | 1 | Marks `rp_rdata` as fresh |
| xfer_req | input | 1 | Copy row `xfer_row` into the line register |
| xfer_row | input | RAW | Row selected for transfer |
| sclk_en | input | 1 | Shift pulse, one cycle wide |
| ser_data | output | DW | Current serial word |
| ser_eol | output | 1 | Line exhausted |

## Verification
The hardest cases involve two things happening to the same row at once. One is a write that lands in the same cycle as that row's transfer. The other is a write that lands mid-line, after the row has been loaded but before its columns have streamed out. The directed tasks build these cases by issuing the write together with `xfer_req`, and by interleaving writes and read-backs between shift pulses. They then walk the rest of the line to show that pre-write words come out for columns already loaded, while the random port reads back the new values.

// File: rtl/dplm_pkg.sv
package dplm_pkg;
  // Address width for a count of n entries, never below one bit.
  function automatic int idx_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/dplm_array.sv
module dplm_array #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 8,
  localparam int RAW = dplm_pkg::idx_w(ROWS),
  localparam int CAW = dplm_pkg::idx_w(COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [RAW-1:0]    row,
  input  logic [CAW-1:0]    col,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [RAW-1:0]    line_row,
  output logic [COLS*DW-1:0] line_data
);
  logic [DW-1:0] mem [ROWS][COLS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[row][col] <= wdata;
    if (rd_en) rdata <= mem[row][col];
  end

  // Whole-row tap used by the line transfer.
  for (genvar c = 0; c < COLS; c++) begin : g_tap
    assign line_data[c*DW +: DW] = mem[line_row][c];
  end

  // R2: a write is visible in the array one cycle later
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(row)][$past(col)] == $past(wdata));
endmodule

// File: rtl/dplm_line_shift.sv
module dplm_line_shift #(
  parameter int COLS = 8,
  parameter int DW   = 8,
  localparam int CAW = dplm_pkg::idx_w(COLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [COLS*DW-1:0] load_data,
  input  logic               step,
  output logic [DW-1:0]      ser_data,
  output logic               ser_eol
);
  logic [DW-1:0]  shreg [COLS];
  logic [CAW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < COLS; i++) shreg[i] <= '0;
      cnt     <= '0;
      ser_eol <= 1'b1;
    end else if (load) begin
      for (int i = 0; i < COLS; i++) shreg[i] <= load_data[i*DW +: DW];
      cnt     <= '0;
      ser_eol <= (COLS == 1);
    end else if (step && !ser_eol) begin
      if (cnt == CAW'(COLS-1)) begin
        ser_eol <= 1'b1;
      end else begin
        for (int i = 0; i < COLS-1; i++) shreg[i] <= shreg[i+1];
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign ser_data = shreg[0];

  // R5: once exhausted, the line stays exhausted and the word holds
  a_r5_eol_holds: assert property (@(posedge clk) disable iff (rst)
    (ser_eol && !load) |=> (ser_eol && $stable(ser_data)));
  // R3: a load restarts the column count
  a_r3_load_restarts: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == '0));
  // R4: no pulse, no movement
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> ($stable(ser_data) && $stable(cnt)));
  // R4: a pulse mid-line advances the column by one
  a_r4_step_advances: assert property (@(posedge clk) disable iff (rst)
    (!load && step && !ser_eol && cnt != CAW'(COLS-1)) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/dual_port_line_mem.sv
module dual_port_line_mem #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 8,
  localparam int RAW = dplm_pkg::idx_w(ROWS),
  localparam int CAW = dplm_pkg::idx_w(COLS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rp_en,
  input  logic           rp_we,
  input  logic [RAW-1:0] rp_row,
  input  logic [CAW-1:0] rp_col,
  input  logic [DW-1:0]  rp_wdata,
  output logic [DW-1:0]  rp_rdata,
  output logic           rp_rvalid,
  input  logic           xfer_req,
  input  logic [RAW-1:0] xfer_row,
  input  logic           sclk_en,
  output logic [DW-1:0]  ser_data,
  output logic           ser_eol
);
  logic               wr_en, rd_en;
  logic [COLS*DW-1:0] row_raw, row_fwd;

  assign wr_en = rp_en && rp_we;
  assign rd_en = rp_en && !rp_we;

  dplm_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_array (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .row(rp_row), .col(rp_col), .wdata(rp_wdata), .rdata(rp_rdata),
    .line_row(xfer_row), .line_data(row_raw)
  );

  // Same-cycle write to the transferred row: forward the new word.
  for (genvar c = 0; c < COLS; c++) begin : g_fwd
    assign row_fwd[c*DW +: DW] =
      (wr_en && rp_row == xfer_row && rp_col == CAW'(c)) ? rp_wdata
                                                          : row_raw[c*DW +: DW];
  end

  dplm_line_shift #(.COLS(COLS), .DW(DW)) u_shift (
    .clk(clk), .rst(rst), .load(xfer_req), .load_data(row_fwd),
    .step(sclk_en), .ser_data(ser_data), .ser_eol(ser_eol)
  );

  always_ff @(posedge clk) begin
    if (rst) rp_rvalid <= 1'b0;
    else     rp_rvalid <= rd_en;
  end

  // R2: read strobe and valid flag line up one cycle apart
  a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rp_rvalid);
  a_r2_rvalid_quiet: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rp_rvalid);
  // R8: a transfer always reopens the line, whatever sclk_en does
  a_r8_xfer_reopens: assert property (@(posedge clk) disable iff (rst)
    xfer_req |=> (COLS == 1 || !ser_eol));
endmodule

// File: tb/dual_port_line_mem_tb.sv
module dual_port_line_mem_tb;
  localparam int ROWS = 8, COLS = 8, DW = 8;
  localparam int RAW = 3, CAW = 3;

  logic clk = 0, rst = 1;
  logic rp_en = 0, rp_we = 0, xfer_req = 0, sclk_en = 0;
  logic [RAW-1:0] rp_row = '0, xfer_row = '0;
  logic [CAW-1:0] rp_col = '0;
  logic [DW-1:0] rp_wdata = '0, rp_rdata, ser_data;
  logic rp_rvalid, ser_eol;

  int total = 0, bad = 0;
  logic [DW-1:0] model [ROWS][COLS];

  always #4 clk = ~clk;

  dual_port_line_mem #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .rp_en(rp_en), .rp_we(rp_we), .rp_row(rp_row),
    .rp_col(rp_col), .rp_wdata(rp_wdata), .rp_rdata(rp_rdata),
    .rp_rvalid(rp_rvalid), .xfer_req(xfer_req), .xfer_row(xfer_row),
    .sclk_en(sclk_en), .ser_data(ser_data), .ser_eol(ser_eol)
  );

  function automatic logic [DW-1:0] pat(int r, int c);
    return DW'((r * 16 + c) ^ 8'h5A);
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs change just after a falling edge; the next falling edge
  // follows the rising edge that used them.
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    rp_en = 0; rp_we = 0; xfer_req = 0; sclk_en = 0;
  endtask

  task automatic wr(int r, int c, logic [DW-1:0] d);
    rp_en = 1; rp_we = 1; rp_row = RAW'(r); rp_col = CAW'(c); rp_wdata = d;
    model[r][c] = d;
    tick(); idle();
  endtask

  task automatic rd_check(string req, int r, int c);
    rp_en = 1; rp_we = 0; rp_row = RAW'(r); rp_col = CAW'(c);
    tick(); idle();
    chk(req, rp_rdata, model[r][c]);
    chk(req, DW'(rp_rvalid), 1);
  endtask

  task automatic xfer(int r);
    xfer_req = 1; xfer_row = RAW'(r);
    tick(); idle();
  endtask

  task automatic pulse();
    sclk_en = 1; tick(); idle();
  endtask

  task automatic t_reset();
    chk("R1", ser_data, 0);
    chk("R1", DW'(ser_eol), 1);
    chk("R1", DW'(rp_rvalid), 0);
  endtask

  task automatic t_fill_and_read();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) wr(r, c, pat(r, c));
    rd_check("R2", 0, 0);
    rd_check("R2", 7, 7);
    rd_check("R2", 4, 2);
    tick();
    chk("R2", DW'(rp_rvalid), 0);
  endtask

  task automatic t_stream();
    xfer(3);
    chk("R3", ser_data, model[3][0]);
    chk("R3", DW'(ser_eol), 0);
    for (int c = 1; c < COLS; c++) begin
      pulse();
      chk("R4", ser_data, model[3][c]);
      tick();
      chk("R4", ser_data, model[3][c]);
    end
    chk("R5", DW'(ser_eol), 0);
    pulse();
    chk("R5", DW'(ser_eol), 1);
    chk("R5", ser_data, model[3][COLS-1]);
    pulse(); pulse();
    chk("R5", DW'(ser_eol), 1);
    chk("R5", ser_data, model[3][COLS-1]);
  endtask

  task automatic t_write_during_stream();
    logic [DW-1:0] snap [COLS];
    xfer(5);
    for (int c = 0; c < COLS; c++) snap[c] = model[5][c];
    chk("R6", ser_data, snap[0]);
    pulse(); pulse();
    wr(5, 4, 8'hC3);
    wr(5, 6, 8'h3C);
    wr(5, 2, 8'hEE);
    rd_check("R6", 5, 4);
    chk("R6", ser_data, snap[2]);
    for (int c = 3; c < COLS; c++) begin
      pulse();
      chk("R6", ser_data, snap[c]);
    end
  endtask

  task automatic t_write_with_xfer();
    rp_en = 1; rp_we = 1; rp_row = 2; rp_col = 0; rp_wdata = 8'hA5;
    model[2][0] = 8'hA5;
    xfer_req = 1; xfer_row = 2;
    tick(); idle();
    chk("R7", ser_data, 8'hA5);
    pulse();
    chk("R7", ser_data, model[2][1]);
  endtask

  task automatic t_xfer_vs_pulse();
    xfer(6);
    pulse(); pulse(); pulse();
    chk("R8", ser_data, model[6][3]);
    xfer_req = 1; xfer_row = 1; sclk_en = 1;
    tick(); idle();
    chk("R8", ser_data, model[1][0]);
    chk("R8", DW'(ser_eol), 0);
  endtask

  task automatic t_read_with_xfer();
    rp_en = 1; rp_we = 0; rp_row = 7; rp_col = 3;
    xfer_req = 1; xfer_row = 7;
    tick(); idle();
    chk("R9", rp_rdata, model[7][3]);
    chk("R9", DW'(rp_rvalid), 1);
    chk("R9", ser_data, model[7][0]);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    tick(); tick();
    rst = 0;
    tick();
    t_reset();
    t_fill_and_read();
    t_stream();
    t_write_during_stream();
    t_write_with_xfer();
    t_xfer_vs_pulse();
    t_read_with_xfer();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule